// File: doc/BRIEF.md
# Multiplexed Grid-Blanked Display Scanner

This block time-multiplexes a segment display. It turns on one grid line at a time and presents the segment pattern stored for that digit. Each digit slot follows a fixed sub-timing. The segment lines come up first, the grid turns on after a short gap, the grid turns off again, and the segments drop after another gap. Segment data therefore changes only while every grid is dark, and one digit's pattern never appears on its neighbour.

A timing step (nominally one microsecond) is divided down from the system clock. Every interval is a count of these steps. Software-side logic loads patterns through a plain address/data/write-enable port into a staging copy of the digit memory. The staging copy is transferred to the displayed copy only at a slot boundary. High-voltage level shifting, character decoding and dimming belong to other blocks.

Top module: `seg_scan`

## Requirements
- R1: While `rst_n` is low, every `grid_o` and `seg_o` bit is 0 and both digit memories are cleared. After release, the scan starts at grid 0 with slot offset 0.
- R2: The slot offset advances by one every `CLK_PER_US` clocks. A slot is `SLOT_US` steps long. After `e` clock edges since reset release, the offset is `(e / CLK_PER_US) % SLOT_US`.
- R3: Grids are served one slot each in ascending index order (`grid_o[i]` is grid i), and the scan wraps from grid `N_GRID-1` back to grid 0.
- R4: At most one `grid_o` bit is high at any time.
- R5: The current grid is high exactly for offsets in [`GRID_ON_US`, `GRID_OFF_US`), which is `(GRID_OFF_US-GRID_ON_US)*CLK_PER_US` clocks per slot.
- R6: `seg_o` carries the current digit's stored pattern exactly for offsets in [`SEG_ON_US`, `SEG_OFF_US`) and is 0 otherwise. The bit order is bits 0..6 = segments a..g, bit 7 = decimal point, bit 8 = indicator.
- R7: `seg_o` changes only at edges where `grid_o` is all zero both before and after the change.
- R8: A write with `wr_en` high stores `wr_data` for digit `wr_addr` in the staging copy. The displayed pattern changes only from the next slot boundary on, so the slot in progress keeps its old pattern.
- R9: A write with `wr_addr >= N_GRID` is ignored and leaves every displayed pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Digit pattern write strobe |
| wr_addr | input | ADDR_W | Digit index to write |
| wr_data | input | 9 | Segment pattern (a..g, decimal point, indicator) |
| grid_o | output | N_GRID | One-hot grid enables, active high |
| seg_o | output | 9 | Segment lines, active high |

## Verification
The checker watches four things on every cycle. It checks that at most one grid is on, and that grids turn on in ascending, wrapping order and start at grid 0 after reset. It checks that each grid-on window lasts the configured number of clocks, and that segment lines move only while all grids are dark. The exact offsets of every edge, the patterns shown, and the rule that a write waits for the next slot boundary depend on what was written and when. Only the bench can show these, because it models the staging and displayed copies from its own write schedule. The same holds for ignored out-of-range writes and the return to grid 0 after a mid-run reset.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W   = 9;
  localparam int SEG_DP  = 7;
  localparam int SEG_IND = 8;
  typedef logic [SEG_W-1:0] seg_pat_t;
endpackage

// File: rtl/seg_scan_tick.sv
module seg_scan_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q == C_LAST) cnt_q <= '0;
        else                      cnt_q <= cnt_q + CW'(1);
      end
      assign tick_o = (cnt_q == C_LAST);
    end
  endgenerate
endmodule

// File: rtl/seg_scan_mem.sv
module seg_scan_mem
  import seg_scan_pkg::*;
#(
  parameter int N_GRID = 12,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(N_GRID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  seg_pat_t          wr_data,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  rd_idx,
  output seg_pat_t          rd_data
);
  seg_pat_t stage_q [N_GRID];
  seg_pat_t show_q  [N_GRID];

  generate
    for (genvar g = 0; g < N_GRID; g++) begin : g_digit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
          show_q[g]  <= '0;
        end else begin
          if (wr_en && (wr_addr == ADDR_W'(g))) stage_q[g] <= wr_data;
          if (commit_i)                         show_q[g]  <= stage_q[g];
        end
      end
    end
  endgenerate

  assign rd_data = show_q[rd_idx];
endmodule

// File: rtl/seg_scan_seq.sv
module seg_scan_seq
  import seg_scan_pkg::*;
#(
  parameter int N_GRID      = 12,
  parameter int SLOT_US     = 778,
  parameter int SEG_ON_US   = 36,
  parameter int GRID_ON_US  = 45,
  parameter int GRID_OFF_US = 720,
  parameter int SEG_OFF_US  = 732,
  localparam int IDX_W = $clog2(N_GRID),
  localparam int T_W   = $clog2(SLOT_US)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  seg_pat_t          pat_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              commit_o,
  output logic [N_GRID-1:0] grid_o,
  output seg_pat_t          seg_o
);
  localparam logic [T_W-1:0]   T_LAST = T_W'(SLOT_US - 1);
  localparam logic [T_W-1:0]   T_SON  = T_W'(SEG_ON_US);
  localparam logic [T_W-1:0]   T_SOFF = T_W'(SEG_OFF_US);
  localparam logic [T_W-1:0]   T_GON  = T_W'(GRID_ON_US);
  localparam logic [T_W-1:0]   T_GOFF = T_W'(GRID_OFF_US);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(N_GRID - 1);

  logic [T_W-1:0]   t_q, t_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             slot_end, grid_win, seg_win;

  always_comb begin
    slot_end = tick_i && (t_q == T_LAST);
    t_nx     = slot_end ? '0 : t_q + T_W'(1);
    idx_nx   = idx_q;
    if (slot_end) idx_nx = (idx_q == I_LAST) ? '0 : idx_q + IDX_W'(1);
    grid_win = (t_nx >= T_GON) && (t_nx < T_GOFF);
    seg_win  = (t_nx >= T_SON) && (t_nx < T_SOFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      idx_q  <= '0;
      grid_o <= '0;
      seg_o  <= '0;
    end else if (tick_i) begin
      t_q    <= t_nx;
      idx_q  <= idx_nx;
      grid_o <= grid_win ? (N_GRID'(1) << idx_nx) : '0;
      seg_o  <= seg_win ? pat_i : '0;
    end
  end

  assign idx_o    = idx_q;
  assign commit_o = slot_end;
endmodule

// File: rtl/seg_scan.sv
module seg_scan
  import seg_scan_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int N_GRID      = 12,
  parameter int ADDR_W      = 4,
  parameter int SLOT_US     = 778,
  parameter int SEG_ON_US   = 36,
  parameter int GRID_ON_US  = 45,
  parameter int GRID_OFF_US = 720,
  parameter int SEG_OFF_US  = 732
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [8:0]        wr_data,
  output logic [N_GRID-1:0] grid_o,
  output logic [8:0]        seg_o
);
  localparam int IDX_W = $clog2(N_GRID);

  logic             tick;
  logic             commit;
  logic [IDX_W-1:0] cur_idx;
  seg_pat_t         cur_pat;

  seg_scan_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  seg_scan_mem #(.N_GRID(N_GRID), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_i(commit), .rd_idx(cur_idx), .rd_data(cur_pat)
  );

  seg_scan_seq #(
    .N_GRID(N_GRID), .SLOT_US(SLOT_US), .SEG_ON_US(SEG_ON_US),
    .GRID_ON_US(GRID_ON_US), .GRID_OFF_US(GRID_OFF_US), .SEG_OFF_US(SEG_OFF_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pat_i(cur_pat),
    .idx_o(cur_idx), .commit_o(commit), .grid_o(grid_o), .seg_o(seg_o)
  );
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int CLK_PER_US  = 50,
  parameter int N_GRID      = 12,
  parameter int GRID_ON_US  = 45,
  parameter int GRID_OFF_US = 720
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_GRID-1:0] grid_o,
  input logic [8:0]        seg_o
);
  localparam int ON_CLKS = (GRID_OFF_US - GRID_ON_US) * CLK_PER_US;

  logic [N_GRID-1:0] last_on;
  int unsigned       on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_on <= '0;
      on_cnt  <= 0;
    end else begin
      if (|grid_o) last_on <= grid_o;
      on_cnt <= (|grid_o) ? on_cnt + 1 : 0;
    end
  end

  AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o)); // R4

  AST_GRID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|grid_o) && (last_on == '0)) |-> grid_o[0]); // R1

  AST_GRID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|grid_o) && (last_on != '0))
      |-> (grid_o == {last_on[N_GRID-2:0], last_on[N_GRID-1]})); // R3

  AST_GRID_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|grid_o) |-> (on_cnt == ON_CLKS)); // R5

  AST_SEG_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_o != $past(seg_o)) |-> ((grid_o == '0) && ($past(grid_o) == '0))); // R7
endmodule

bind seg_scan seg_scan_chk #(
  .CLK_PER_US(CLK_PER_US), .N_GRID(N_GRID),
  .GRID_ON_US(GRID_ON_US), .GRID_OFF_US(GRID_OFF_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grid_o(grid_o), .seg_o(seg_o)
);

// File: tb/seg_scan_bench.sv
module seg_scan_bench;
  localparam int C   = 2;
  localparam int N   = 4;
  localparam int AW  = 3;
  localparam int S   = 20;
  localparam int SON = 3;
  localparam int GON = 5;
  localparam int GOF = 15;
  localparam int SOF = 17;
  localparam int SCAN = C * S * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [8:0]    wr_data = '0;
  logic [N-1:0]  grid_o;
  logic [8:0]    seg_o;

  int checks = 0;
  int errors = 0;
  int e = 0;
  bit done = 0;
  logic [8:0] m_wr [N];
  logic [8:0] m_show [N];

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) e <= 0; else e <= e + 1;

  seg_scan #(
    .CLK_PER_US(C), .N_GRID(N), .ADDR_W(AW), .SLOT_US(S),
    .SEG_ON_US(SON), .GRID_ON_US(GON), .GRID_OFF_US(GOF), .SEG_OFF_US(SOF)
  ) u_seg_scan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .grid_o(grid_o), .seg_o(seg_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at e=%0d: actual %h expected %h", tag, e, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_wr[i] = '0;
      m_show[i] = '0;
    end
  endtask

  // one scan-sweep sample: model (R2 offsets) compared to ports
  task automatic sample();
    int k, t, slot, idx;
    logic [N-1:0] g_exp;
    logic [8:0]   s_exp;
    if (e > 0 && (e % (C * S)) == 0)
      for (int i = 0; i < N; i++) m_show[i] = m_wr[i];
    k = e / C;
    t = k % S;
    slot = k / S;
    idx = slot % N;
    g_exp = (t >= GON && t < GOF) ? N'(1) << idx : '0;
    s_exp = (t >= SON && t < SOF) ? m_show[idx] : '0;
    chk("R2/R3/R5 grid", 16'(grid_o), 16'(g_exp));
    chk("R6/R8/R9 seg", 16'(seg_o), 16'(s_exp));
  endtask

  task automatic drive();
    int slot, a;
    logic [8:0] p;
    wr_en = 1'b0;
    if ((e % (C * S)) == 8 * C) begin
      slot = e / (C * S);
      p = 9'((slot * 73 + 17) ^ (slot << 5)) | 9'(1 << (slot % 9));
      if (slot % 3 == 2) a = N + (slot % (8 - N));   // R9 out of range
      else if (slot % 2 == 0) a = (slot % N);        // R8 current digit
      else a = (slot + 1) % N;                       // R8 next digit
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = p;
      if (a < N) m_wr[a] = p;
    end
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk("R1 reset grid", 16'(grid_o), 16'h0);
    chk("R1 reset seg", 16'(seg_o), 16'h0);
    rst_n = 1'b1;
    for (int c = 0; c < 3 * SCAN + 10; c++) begin
      @(negedge clk);
      sample();
      drive();
    end
    // mid-run reset: outputs clear, memory clear, scan restarts at grid 0
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    chk("R1 midrun grid", 16'(grid_o), 16'h0);
    chk("R1 midrun seg", 16'(seg_o), 16'h0);
    rst_n = 1'b1;
    for (int c = 0; c < SCAN + 10; c++) begin
      @(negedge clk);
      sample();
      drive();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule